// File: doc/BRIEF.md
# USB IN Endpoint Transmit Buffer

This block holds one outgoing packet for a single USB IN endpoint. The processor pushes bytes one at a time into a byte-wide buffer. It then signals that the packet is ready. The serial interface engine reads the bytes out in the order they were written and reports at the end of the transaction whether the host accepted the packet. On success the buffer empties and is handed back to the processor. On a failed or refused transaction the read position goes back to the first byte, so the same packet is sent again.

A parameter picks one of two flavours. The data-endpoint flavour can raise the ready flag by itself once the byte count reaches a programmed maximum packet size. The control-endpoint flavour drops that feature and adds two things. An abort input marks the end of a setup stage and throws the current packet away. A data-end flag is set by the processor alongside the last data packet and cleared when the status stage finishes. The buffer depth is a parameter: 32 bytes suits most endpoints, and 128 bytes suits a large bulk endpoint.

Top module: `usb_in_ep_txfifo`

## Requirements
- R1: After a synchronous reset, `pkt_rdy` and `data_end` are 0, `byte_cnt` is 0 and `sie_rd_data` is 0x00.
- R2: While `pkt_rdy` is 0, each cycle with `cpu_wr_en` high stores `cpu_wr_data` and raises `byte_cnt` by one. The engine reads the bytes back in write order, and each `sie_rd_en` cycle moves to the next byte.
- R3: While `pkt_rdy` is 1, writes are ignored. `byte_cnt` holds and the stored bytes are unchanged.
- R4: `byte_cnt` never exceeds DEPTH. A write while `byte_cnt` equals DEPTH is dropped.
- R5: A `cpu_set_pkt_rdy` pulse makes `pkt_rdy` read 1 after the next clock edge. This is how a short packet is sent.
- R6: In data mode with `cfg_auto_set`=1, the write that brings `byte_cnt` to `cfg_max_pkt` also sets `pkt_rdy` at the same edge. With `cfg_auto_set`=0 the flag stays 0.
- R7: A `sie_tx_ok` pulse while `pkt_rdy` is 1 clears `pkt_rdy` and `byte_cnt` at the next edge. The next byte written goes to the first slot.
- R8: A `sie_tx_fail` pulse returns the read position to the first byte of the packet. `pkt_rdy` and `byte_cnt` are unchanged.
- R9: In control mode, a `setup_end` pulse clears `pkt_rdy` and empties the buffer at the next edge.
- R10: In control mode, `cpu_set_data_end` sets `data_end` and `status_done` clears it. If both come in the same cycle, the clear wins. The flag does not depend on packet completion.
- R11: In control mode, auto-set has no effect. In data mode, `setup_end` and `cpu_set_data_end` are ignored, and `data_end` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor byte write strobe |
| cpu_wr_data | input | 8 | Processor write byte |
| cpu_set_pkt_rdy | input | 1 | Processor pulse marking the packet ready |
| cpu_set_data_end | input | 1 | Processor pulse setting the data-end flag (control mode) |
| cfg_auto_set | input | 1 | Enables automatic ready at max packet size (data mode) |
| cfg_max_pkt | input | $clog2(DEPTH+1) | Programmed maximum packet size in bytes |
| sie_rd_en | input | 1 | Engine pulse advancing to the next byte |
| sie_tx_ok | input | 1 | Engine pulse: host acknowledged the packet |
| sie_tx_fail | input | 1 | Engine pulse: transaction failed or refused, resend later |
| setup_end | input | 1 | Setup-stage abort (control mode) |
| status_done | input | 1 | Status stage completed (control mode) |
| pkt_rdy | output | 1 | Packet ready for transmission |
| data_end | output | 1 | Final data packet flag (control mode) |
| byte_cnt | output | $clog2(DEPTH+1) | Bytes held in the buffer |
| sie_rd_data | output | 8 | Byte at the current read position |

## Verification
Every flag and the byte count are registered, so a stimulus applied before a rising edge shows its effect one edge later. The read byte is taken combinationally from the stored data at the registered read position. It therefore follows a write, a read advance or a rewind after that same single edge. The bench drives each stimulus on a falling edge and samples the outputs on the next falling edge. That places every check half a period after the one edge that should have produced the result. Directed sequences also look at the cycle right after an ignored write or abort, before any further stimulus.

// File: rtl/usb_txfifo_pkg.sv
package usb_txfifo_pkg;

    typedef enum logic {
        EP_DATA    = 1'b0,
        EP_CONTROL = 1'b1
    } ep_kind_e;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // one-cycle command set applied to the byte store
    typedef struct packed {
        logic flush;    // empty the store and reset the read position
        logic rewind;   // return the read position to the first byte
        logic advance;  // step to the next stored byte
        logic push;     // append a byte
    } fifo_op_t;

    function automatic int cnt_bits(input int depth);
        return $clog2(depth + 1);
    endfunction

    function automatic int idx_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/txfifo_store.sv
module txfifo_store
    import usb_txfifo_pkg::*;
#(
    parameter int  DEPTH = 32,
    localparam int CNT_W = cnt_bits(DEPTH),
    localparam int IDX_W = idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_op_t         op,
    input  byte_t            wr_data,
    output logic [CNT_W-1:0] count,
    output byte_t            rd_data,
    output logic             full
);

    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    byte_t            mem [DEPTH];
    logic [CNT_W-1:0] rd_pos;
    logic             push_ok;

    assign full    = (count == DEPTH_C);
    assign push_ok = op.push && !full && !op.flush;

    // packets always start at slot 0, so the byte count doubles as write index
    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            rd_pos <= '0;
        end else if (op.flush) begin
            count  <= '0;
            rd_pos <= '0;
        end else begin
            if (push_ok) begin
                count <= count + CNT_W'(1);
            end
            if (op.rewind) begin
                rd_pos <= '0;
            end else if (op.advance && (rd_pos < count)) begin
                rd_pos <= rd_pos + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push_ok) begin
            mem[count[IDX_W-1:0]] <= wr_data;
        end
    end

    always_comb begin
        if (rd_pos < DEPTH_C) begin
            rd_data = mem[rd_pos[IDX_W-1:0]];
        end else begin
            rd_data = '0;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);                                               // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        full && !op.flush |=> full);                                     // R4
    AST_REWIND_FIRST: assert property (@(posedge clk) disable iff (rst)
        op.rewind && !op.flush && !push_ok |=> rd_data == mem[0]);       // R8

endmodule

// File: rtl/pkt_ready_ctl.sv
module pkt_ready_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sw_set,
    input  logic auto_hit,
    input  logic sent,
    input  logic abort,
    output logic rdy
);

    // clearing events outrank setting events
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b0;
        end else if (abort || sent) begin
            rdy <= 1'b0;
        end else if (sw_set || auto_hit) begin
            rdy <= 1'b1;
        end
    end

    AST_SENT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        sent |=> !rdy);                                                  // R7
    AST_SW_SETS: assert property (@(posedge clk) disable iff (rst)
        sw_set && !abort && !sent |=> rdy);                              // R5

endmodule

// File: rtl/data_end_ctl.sv
module data_end_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sw_set,
    input  logic status_done,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (status_done) begin
            flag <= 1'b0;
        end else if (sw_set) begin
            flag <= 1'b1;
        end
    end

    AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        status_done |=> !flag);                                          // R10
    AST_DE_SETS: assert property (@(posedge clk) disable iff (rst)
        sw_set && !status_done |=> flag);                                // R10

endmodule

// File: rtl/usb_in_ep_txfifo.sv
module usb_in_ep_txfifo
    import usb_txfifo_pkg::*;
#(
    parameter int       DEPTH   = 32,
    parameter ep_kind_e EP_KIND = EP_DATA,
    localparam int      CNT_W   = cnt_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr_en,
    input  logic [7:0]       cpu_wr_data,
    input  logic             cpu_set_pkt_rdy,
    input  logic             cpu_set_data_end,
    input  logic             cfg_auto_set,
    input  logic [CNT_W-1:0] cfg_max_pkt,
    input  logic             sie_rd_en,
    input  logic             sie_tx_ok,
    input  logic             sie_tx_fail,
    input  logic             setup_end,
    input  logic             status_done,
    output logic             pkt_rdy,
    output logic             data_end,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [7:0]       sie_rd_data
);

    fifo_op_t op;
    logic     full;
    logic     abort;
    logic     auto_hit;
    logic     sent;
    logic     accept;

    assign sent   = sie_tx_ok && pkt_rdy;
    assign accept = cpu_wr_en && !pkt_rdy && !full && !abort;

    always_comb begin
        op         = '0;
        op.flush   = abort || sent;
        op.rewind  = sie_tx_fail;
        op.advance = sie_rd_en && pkt_rdy;
        op.push    = cpu_wr_en && !pkt_rdy;
    end

    generate
        if (EP_KIND == EP_CONTROL) begin : g_ctrl
            logic unused_auto_cfg;
            assign unused_auto_cfg = ^{cfg_auto_set, cfg_max_pkt};
            assign abort    = setup_end;
            assign auto_hit = 1'b0;

            data_end_ctl u_data_end (
                .clk        (clk),
                .rst        (rst),
                .sw_set     (cpu_set_data_end),
                .status_done(status_done),
                .flag       (data_end)
            );

            AST_SETUP_FLUSH: assert property (@(posedge clk) disable iff (rst)
                setup_end |=> (byte_cnt == '0) && !pkt_rdy);             // R9
        end else begin : g_data
            logic unused_ctrl_in;
            assign unused_ctrl_in = ^{cpu_set_data_end, status_done, setup_end};
            assign abort    = 1'b0;
            assign auto_hit = cfg_auto_set && accept
                              && ((byte_cnt + CNT_W'(1)) == cfg_max_pkt);
            assign data_end = 1'b0;

            AST_AUTO_SET: assert property (@(posedge clk) disable iff (rst)
                cfg_auto_set && accept && (byte_cnt + CNT_W'(1) == cfg_max_pkt)
                |=> pkt_rdy);                                            // R6
            AST_SETUP_IGNORED: assert property (@(posedge clk) disable iff (rst)
                setup_end && pkt_rdy && !sie_tx_ok |=> $stable(byte_cnt)); // R11
        end
    endgenerate

    txfifo_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .wr_data(cpu_wr_data),
        .count  (byte_cnt),
        .rd_data(sie_rd_data),
        .full   (full)
    );

    pkt_ready_ctl u_ready (
        .clk     (clk),
        .rst     (rst),
        .sw_set  (cpu_set_pkt_rdy),
        .auto_hit(auto_hit),
        .sent    (sent),
        .abort   (abort),
        .rdy     (pkt_rdy)
    );

    AST_HOLD_WHEN_RDY: assert property (@(posedge clk) disable iff (rst)
        pkt_rdy && !abort && !sie_tx_ok |=> $stable(byte_cnt));          // R3

endmodule

// File: tb/usb_in_ep_txfifo_bench.sv
module usb_in_ep_txfifo_bench;
    import usb_txfifo_pkg::*;

    localparam int DEPTH = 32;
    localparam int CW    = cnt_bits(DEPTH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // data-mode instance
    logic          wr_en = 0, set_rdy = 0, set_de = 0, auto_set = 0;
    logic          rd_en = 0, tx_ok = 0, tx_fail = 0, stp_end = 0, st_done = 0;
    logic [7:0]    wr_data = 0;
    logic [CW-1:0] max_pkt = 0;
    logic          rdy, de;
    logic [CW-1:0] cnt;
    logic [7:0]    rdata;

    // control-mode instance
    logic          c_wr_en = 0, c_set_rdy = 0, c_set_de = 0, c_auto = 0;
    logic          c_rd_en = 0, c_tx_ok = 0, c_tx_fail = 0, c_stp = 0, c_st_done = 0;
    logic [7:0]    c_wr_data = 0;
    logic [CW-1:0] c_max = 0;
    logic          c_rdy, c_de;
    logic [CW-1:0] c_cnt;
    logic [7:0]    c_rdata;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    usb_in_ep_txfifo #(.DEPTH(DEPTH), .EP_KIND(EP_DATA)) u_usb_in_ep_txfifo (
        .clk(clk), .rst(rst), .cpu_wr_en(wr_en), .cpu_wr_data(wr_data),
        .cpu_set_pkt_rdy(set_rdy), .cpu_set_data_end(set_de),
        .cfg_auto_set(auto_set), .cfg_max_pkt(max_pkt), .sie_rd_en(rd_en),
        .sie_tx_ok(tx_ok), .sie_tx_fail(tx_fail), .setup_end(stp_end),
        .status_done(st_done), .pkt_rdy(rdy), .data_end(de),
        .byte_cnt(cnt), .sie_rd_data(rdata)
    );

    usb_in_ep_txfifo #(.DEPTH(DEPTH), .EP_KIND(EP_CONTROL)) u_usb_in_ep_txfifo_ctl (
        .clk(clk), .rst(rst), .cpu_wr_en(c_wr_en), .cpu_wr_data(c_wr_data),
        .cpu_set_pkt_rdy(c_set_rdy), .cpu_set_data_end(c_set_de),
        .cfg_auto_set(c_auto), .cfg_max_pkt(c_max), .sie_rd_en(c_rd_en),
        .sie_tx_ok(c_tx_ok), .sie_tx_fail(c_tx_fail), .setup_end(c_stp),
        .status_done(c_st_done), .pkt_rdy(c_rdy), .data_end(c_de),
        .byte_cnt(c_cnt), .sie_rd_data(c_rdata)
    );

    // {2'b0, exp_rdy, wr set rd ok fail, wdata, exp_cnt, exp_rd_data}
    localparam int NVEC = 13;
    localparam logic [31:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 5'b10000, 8'hA1, 8'd1, 8'hA1},   // R2
        {2'b00, 1'b0, 5'b10000, 8'hB2, 8'd2, 8'hA1},   // R2
        {2'b00, 1'b1, 5'b10000, 8'hC3, 8'd3, 8'hA1},   // R6 auto-set at 3
        {2'b00, 1'b1, 5'b10000, 8'hD4, 8'd3, 8'hA1},   // R3 write ignored
        {2'b00, 1'b1, 5'b00100, 8'h00, 8'd3, 8'hB2},   // R2 read order
        {2'b00, 1'b1, 5'b00100, 8'h00, 8'd3, 8'hC3},   // R2
        {2'b00, 1'b1, 5'b00001, 8'h00, 8'd3, 8'hA1},   // R8 rewind
        {2'b00, 1'b1, 5'b00100, 8'h00, 8'd3, 8'hB2},   // R8 resend
        {2'b00, 1'b0, 5'b00010, 8'h00, 8'd0, 8'hA1},   // R7 sent
        {2'b00, 1'b0, 5'b10000, 8'h5E, 8'd1, 8'h5E},   // R7 slot 0 reused
        {2'b00, 1'b1, 5'b01000, 8'h00, 8'd1, 8'h5E},   // R5 short packet
        {2'b00, 1'b1, 5'b00100, 8'h00, 8'd1, 8'hB2},   // R3 slot 1 unchanged
        {2'b00, 1'b0, 5'b00010, 8'h00, 8'd0, 8'h5E}    // R7
    };

    function automatic string vec_tag(input int i);
        case (i)
            2:       return "R6";
            3, 11:   return "R3";
            6, 7:    return "R8";
            8, 9,12: return "R7";
            10:      return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clear_d();
        wr_en = 0; set_rdy = 0; set_de = 0; rd_en = 0;
        tx_ok = 0; tx_fail = 0; stp_end = 0; st_done = 0;
    endtask

    task automatic clear_c();
        c_wr_en = 0; c_set_rdy = 0; c_set_de = 0; c_rd_en = 0;
        c_tx_ok = 0; c_tx_fail = 0; c_stp = 0; c_st_done = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        // R1 reset state
        check("R1", {31'd0, rdy}, 0);
        check("R1", {31'd0, de}, 0);
        check("R1", 32'(cnt), 0);
        check("R1", 32'(rdata), 0);
        check("R1", {31'd0, c_rdy}, 0);
        check("R1", 32'(c_cnt), 0);

        // vector table on the data-mode instance
        auto_set = 1; max_pkt = CW'(3);
        for (int i = 0; i < NVEC; i++) begin
            {wr_en, set_rdy, rd_en, tx_ok, tx_fail} = VEC[i][28:24];
            wr_data = VEC[i][23:16];
            tick();
            clear_d();
            check(vec_tag(i), {31'd0, rdy}, {31'd0, VEC[i][29]});
            check(vec_tag(i), 32'(cnt), 32'(VEC[i][15:8]));
            check(vec_tag(i), 32'(rdata), 32'(VEC[i][7:0]));
        end

        // R4 / R6: fill past depth with auto-set off
        auto_set = 0;
        for (int i = 0; i < DEPTH + 1; i++) begin
            wr_en = 1; wr_data = 8'(i);
            tick();
            if (i == 2) check("R6", {31'd0, rdy}, 0);
        end
        clear_d();
        check("R4", 32'(cnt), DEPTH);
        check("R6", {31'd0, rdy}, 0);
        set_rdy = 1; tick(); clear_d();
        check("R2", 32'(rdata), 0);
        for (int i = 0; i < DEPTH - 1; i++) begin
            rd_en = 1; tick();
        end
        clear_d();
        check("R4", 32'(rdata), DEPTH - 1);
        tx_ok = 1; tick(); clear_d();
        check("R7", 32'(cnt), 0);

        // R11 data mode ignores abort and data-end controls
        wr_en = 1; wr_data = 8'h77; tick(); clear_d();
        stp_end = 1; set_de = 1; tick(); clear_d();
        check("R11", 32'(cnt), 1);
        check("R11", {31'd0, de}, 0);
        check("R11", 32'(rdata), 8'h77);

        // control-mode instance
        c_auto = 1; c_max = CW'(2);
        c_wr_en = 1; c_wr_data = 8'h11; tick();
        c_wr_data = 8'h22; tick(); clear_c();
        check("R11", {31'd0, c_rdy}, 0);
        check("R11", 32'(c_cnt), 2);
        c_set_rdy = 1; tick(); clear_c();
        check("R5", {31'd0, c_rdy}, 1);
        c_wr_en = 1; c_wr_data = 8'h33; tick(); clear_c();
        check("R3", 32'(c_cnt), 2);
        c_stp = 1; tick(); clear_c();
        check("R9", {31'd0, c_rdy}, 0);
        check("R9", 32'(c_cnt), 0);
        c_wr_en = 1; c_wr_data = 8'h44; tick(); clear_c();
        check("R9", 32'(c_rdata), 8'h44);
        check("R9", 32'(c_cnt), 1);
        c_set_de = 1; tick(); clear_c();
        check("R10", {31'd0, c_de}, 1);
        c_st_done = 1; tick(); clear_c();
        check("R10", {31'd0, c_de}, 0);
        c_set_de = 1; c_st_done = 1; tick(); clear_c();
        check("R10", {31'd0, c_de}, 0);
        c_set_de = 1; c_set_rdy = 1; tick(); clear_c();
        c_tx_ok = 1; tick(); clear_c();
        check("R7", {31'd0, c_rdy}, 0);
        check("R10", {31'd0, c_de}, 1);
        c_st_done = 1; tick(); clear_c();
        check("R10", {31'd0, c_de}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule